// File: doc/BRIEF.md
# Programmable Address Chip Select Unit

This block turns a bus address and the read and write strobes into five active-low chip select pins. Select 0 is the fallback: it drives whenever no other enabled region claims the address. Selects 1 to 4 each own a programmable window. A window has a base address and a power-of-two size of at least 4 KB, and it can be qualified by address alone, by the read strobe or by the write strobe.

Windows may overlap only in two fixed pairings: region 4 may sit over region 3, and region 2 over region 1. Inside a legal overlap the higher-numbered region wins. Any other combination of hits is flagged as a bus error, and while the error is flagged no select is driven. A two-bit boot field, sampled while reset is held, decides how many of the five pins may ever go low. A region whose pin is not enabled still claims its addresses, so select 0 stays off there as well.

Every cycle is an independent combinational decode followed by one output register. Nothing is queued, so the block has no stream interface and applies no back-pressure. The software write port is a plain single-cycle strobe.

Top module: `csel_unit`

## Requirements
- R1: While and after reset, every `cs_n` bit is 1, `bus_err` is 0 and all four regions are disabled.
- R2: With `addr_vld` high and no enabled region matching, `cs_n[0]` is 0 and the other bits are 1.
- R3: Region k (1..4) matches when address bits from 12+S up to the top equal the same bits of its base, where S is the size code (window = 4 KB << S). The region word carries the base in bits [AW-1:12] and S in bits [3:0] (at the defaults). Base bits below 12+S are ignored.
- R4: When region 4 overlaps 3, or region 2 overlaps 1, the higher number drives its select and the lower one stays inactive. At most one `cs_n` bit is ever 0.
- R5: A hit set that spans both pairs {1,2} and {3,4} drives `bus_err` to 1 and holds all `cs_n` bits at 1.
- R6: Control word bit 0 is the enable and bits [2:1] are the qualifier: 00 or 11 means address, 01 means read, 10 means write. A read-qualified winner drives its select only while `rd_stb` is 1, and a write-qualified winner only while `wr_stb` is 1. Otherwise no select is driven.
- R7: `boot_cs_cnt` is sampled while reset is held and kept until the next reset. It enables pins as follows: 11 enables 0..4, 00 enables 0..2, 01 enables 0..1, and 10 enables none. A disabled pin stays 1 even when its region claims the address.
- R8: A region with its enable bit at 0 never takes part in decoding, even after its region word has been written.
- R9: `cs_n` and `bus_err` are registered and reflect the inputs one clock earlier. With `addr_vld` at 0, all selects are 1 and `bus_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_cs_cnt | input | 2 | Pin-count field sampled during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Target region, 0 selects region 1, 3 selects region 4 |
| cfg_ctl | input | 1 | 1 writes the control word, 0 writes the region word |
| cfg_wdata | input | AW | Write data |
| addr_vld | input | 1 | Bus address valid |
| addr | input | AW | Bus address |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| cs_n | output | 5 | Chip selects, active low, bit k is select k |
| bus_err | output | 1 | Illegal overlap flag |

## Verification
The bench builds the block with AW=20 and MIN_LOG=12, so the whole space is 1 MB. Windows from 4 KB up to 128 KB, and their upper and lower edges, can be reached with short hand-picked addresses. The small space allows two stacked legal overlaps, and one illegal three-way hit, to be arranged at a single address. The bench repeats reset with each of the four boot codes, including a change of the boot pins after reset is released, to cover the pin-count table.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CSEL_NREG = 4;               // programmable regions (pairs of two)
  localparam int CSEL_NPIN = CSEL_NREG + 1;   // plus the default select

  typedef enum logic [1:0] {
    QUAL_ADDR  = 2'b00,
    QUAL_READ  = 2'b01,
    QUAL_WRITE = 2'b10,
    QUAL_ADDR2 = 2'b11
  } qual_e;

  // pin enable mask from the boot field
  function automatic logic [CSEL_NPIN-1:0] pin_mask(input logic [1:0] code);
    case (code)
      2'b11:   pin_mask = 5'b11111;
      2'b00:   pin_mask = 5'b00111;
      2'b01:   pin_mask = 5'b00011;
      default: pin_mask = 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/csel_region.sv
module csel_region
  import csel_pkg::*;
#(
  parameter int AW      = 24,
  parameter int MIN_LOG = 12,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rgn,
  input  logic          wr_ctl,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output qual_e         qual
);
  localparam int HW = AW - MIN_LOG;

  logic [HW-1:0] base_q;
  logic [SW-1:0] size_q;
  logic          en_q;
  qual_e         qual_q;
  logic [HW-1:0] keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
      qual_q <= QUAL_ADDR;
    end else begin
      if (wr_rgn) begin
        base_q <= wdata[AW-1:MIN_LOG];
        size_q <= wdata[SW-1:0];
      end
      if (wr_ctl) begin
        en_q   <= wdata[0];
        qual_q <= qual_e'(wdata[2:1]);
      end
    end
  end

  // compare only bits at or above the window size
  always_comb begin
    for (int i = 0; i < HW; i++) keep[i] = (i >= int'(size_q));
  end

  assign hit  = en_q && (((addr[AW-1:MIN_LOG] ^ base_q) & keep) == '0);
  assign qual = qual_q;
endmodule

// File: rtl/csel_resolve.sv
module csel_resolve
  import csel_pkg::*;
(
  input  logic                 addr_vld,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic [CSEL_NREG-1:0] hit,
  input  qual_e                qual [CSEL_NREG],
  output logic [CSEL_NPIN-1:0] sel,
  output logic                 err
);
  localparam int NPAIR = CSEL_NREG / 2;

  logic [NPAIR-1:0] pair_hit;
  logic             found;
  int               win;

  always_comb begin
    for (int j = 0; j < NPAIR; j++) pair_hit[j] = hit[2*j] | hit[2*j+1];
    found = 1'b0;
    win   = 0;
    for (int k = CSEL_NREG - 1; k >= 0; k--) begin
      if (!found && hit[k]) begin
        found = 1'b1;
        win   = k;
      end
    end
    err = addr_vld && ($countones(pair_hit) > 1);
    sel = '0;
    if (addr_vld && !err) begin
      if (!found) sel[0] = 1'b1;
      else begin
        case (qual[win])
          QUAL_READ:  sel[win+1] = rd_stb;
          QUAL_WRITE: sel[win+1] = wr_stb;
          default:    sel[win+1] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int AW      = 24,
  parameter int MIN_LOG = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   boot_cs_cnt,
  input  logic                         cfg_we,
  input  logic [$clog2(CSEL_NREG)-1:0] cfg_idx,
  input  logic                         cfg_ctl,
  input  logic [AW-1:0]                cfg_wdata,
  input  logic                         addr_vld,
  input  logic [AW-1:0]                addr,
  input  logic                         rd_stb,
  input  logic                         wr_stb,
  output logic [CSEL_NPIN-1:0]         cs_n,
  output logic                         bus_err
);
  localparam int SW = $clog2(AW - MIN_LOG + 1);

  logic [1:0]           cnt_q;
  logic [CSEL_NREG-1:0] hit;
  qual_e                qual [CSEL_NREG];
  logic [CSEL_NPIN-1:0] sel;
  logic                 err;

  // boot field follows the pins while reset is held, then freezes
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= boot_cs_cnt;
  end

  for (genvar g = 0; g < CSEL_NREG; g++) begin : g_rgn
    csel_region #(.AW(AW), .MIN_LOG(MIN_LOG), .SW(SW)) u_rgn (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_rgn (cfg_we && !cfg_ctl && (cfg_idx == g)),
      .wr_ctl (cfg_we &&  cfg_ctl && (cfg_idx == g)),
      .wdata  (cfg_wdata),
      .addr   (addr),
      .hit    (hit[g]),
      .qual   (qual[g])
    );
  end

  csel_resolve u_res (
    .addr_vld (addr_vld),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .hit      (hit),
    .qual     (qual),
    .sel      (sel),
    .err      (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= '1;
      bus_err <= 1'b0;
    end else begin
      cs_n    <= ~(sel & pin_mask(cnt_q));
      bus_err <= err;
    end
  end
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_vld,
  input logic [4:0] cs_n,
  input logic       bus_err,
  input logic [1:0] cnt_q
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (&cs_n)); // R5
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ((&cs_n) && !bus_err)); // R9
  AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cnt_q)); // R7
  AST_NO_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 2'b10) |-> (&cs_n)); // R7
  AST_TWO_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 2'b01) |-> (&cs_n[4:2])); // R7
endmodule

bind csel_unit csel_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_vld (addr_vld),
  .cs_n     (cs_n),
  .bus_err  (bus_err),
  .cnt_q    (cnt_q)
);

// File: tb/csel_unit_test.sv
module csel_unit_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    boot_cs_cnt = 2'b11;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic          cfg_ctl = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          addr_vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_stb = 1'b0;
  logic          wr_stb = 1'b0;
  logic [4:0]    cs_n;
  logic          bus_err;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [4:0] cs;
    logic       err;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;   // 125 MHz

  csel_unit #(.AW(AW), .MIN_LOG(12)) uut (
    .clk(clk), .rst_n(rst_n), .boot_cs_cnt(boot_cs_cnt),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ctl(cfg_ctl), .cfg_wdata(cfg_wdata),
    .addr_vld(addr_vld), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .cs_n(cs_n), .bus_err(bus_err)
  );

  // monitor: compares one registered result just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cs_n !== e.cs || bus_err !== e.err) begin
          errors++;
          $display("FAIL %s: cs_n=%b err=%b expected cs_n=%b err=%b",
                   e.tag, cs_n, bus_err, e.cs, e.err);
        end
      end
    end
  end

  task automatic do_reset(input logic [1:0] boot);
    rst_n = 1'b0;
    boot_cs_cnt = boot;
    addr_vld = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input int idx, input bit ctl, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_ctl = ctl; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic vld, input logic [AW-1:0] a, input logic rd,
                       input logic wr, input logic [4:0] ecs, input logic eerr,
                       input string tag);
    exp_t e;
    addr_vld = vld; addr = a; rd_stb = rd; wr_stb = wr;
    e.cs = ecs; e.err = eerr; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: state while reset is held
    checks++;
    if (cs_n !== 5'b11111 || bus_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: cs_n=%b err=%b expected 11111 0", cs_n, bus_err);
    end
    do_reset(2'b11);

    drive(1, 20'h12345, 0, 0, 5'b11110, 0, "R2 default select");
    drive(1, 20'h00000, 0, 0, 5'b11110, 0, "R1 regions disabled after reset");
    // region 1: base 0x40000, 128 KB (code 5), stray bit 12 in base
    wr_reg(0, 0, 20'h41005);
    drive(1, 20'h40010, 0, 0, 5'b11110, 0, "R8 written but not enabled");
    wr_reg(0, 1, 20'h00001);
    drive(1, 20'h40010, 0, 0, 5'b11101, 0, "R3 low base bit ignored");
    drive(1, 20'h5FFFF, 0, 0, 5'b11101, 0, "R3 window top");
    drive(1, 20'h60000, 0, 0, 5'b11110, 0, "R3 above window");
    drive(1, 20'h3FFFF, 0, 0, 5'b11110, 0, "R3 below window");
    // region 2 inside region 1, 4 KB
    wr_reg(1, 0, 20'h50000);
    wr_reg(1, 1, 20'h00001);
    drive(1, 20'h50800, 0, 0, 5'b11011, 0, "R4 2 over 1");
    drive(1, 20'h51000, 0, 0, 5'b11101, 0, "R4 past region 2");
    // region 3 read-qualified, 4 KB, base bits 11:4 junk
    wr_reg(2, 0, 20'h80AB0);
    wr_reg(2, 1, 20'h00003);
    drive(1, 20'h80FFF, 0, 0, 5'b11111, 0, "R6 read idle");
    drive(1, 20'h80FFF, 1, 0, 5'b10111, 0, "R6 read strobe");
    drive(1, 20'h81000, 1, 0, 5'b11110, 0, "R3 past region 3");
    // region 4 write-qualified, 64 KB
    wr_reg(3, 0, 20'hC0004);
    wr_reg(3, 1, 20'h00005);
    drive(1, 20'hC1234, 0, 1, 5'b01111, 0, "R6 write strobe");
    drive(1, 20'hC1234, 1, 0, 5'b11111, 0, "R6 read on write region");
    // move region 4 over region 3
    wr_reg(3, 0, 20'h80004);
    drive(1, 20'h80010, 0, 1, 5'b01111, 0, "R4 4 over 3");
    drive(1, 20'h80010, 1, 0, 5'b11111, 0, "R4 winner qualifier");
    // move region 2 into the same spot: illegal
    wr_reg(1, 0, 20'h80000);
    drive(1, 20'h80010, 0, 1, 5'b11111, 1, "R5 illegal overlap");
    drive(1, 20'h50000, 0, 0, 5'b11101, 0, "R5 error clears");
    drive(0, 20'h80010, 0, 1, 5'b11111, 0, "R9 address not valid");
    drive(1, 20'h00000, 0, 0, 5'b11110, 0, "R9 one cycle latency");

    // two pins
    do_reset(2'b01);
    wr_reg(1, 0, 20'h50000);
    wr_reg(1, 1, 20'h00001);
    drive(1, 20'h50000, 0, 0, 5'b11111, 0, "R7 two pins, region 2 claims");
    drive(1, 20'h00000, 0, 0, 5'b11110, 0, "R7 two pins default");
    wr_reg(0, 0, 20'h40005);
    wr_reg(0, 1, 20'h00001);
    drive(1, 20'h40000, 0, 0, 5'b11101, 0, "R7 two pins region 1");

    // three pins
    do_reset(2'b00);
    wr_reg(2, 0, 20'h80000);
    wr_reg(2, 1, 20'h00001);
    drive(1, 20'h80000, 0, 0, 5'b11111, 0, "R7 three pins, region 3 claims");
    wr_reg(1, 0, 20'h50000);
    wr_reg(1, 1, 20'h00001);
    drive(1, 20'h50000, 0, 0, 5'b11011, 0, "R7 three pins region 2");

    // no pins, boot pins changed after release
    do_reset(2'b10);
    boot_cs_cnt = 2'b11;
    drive(1, 20'h00000, 0, 0, 5'b11111, 0, "R7 none enabled, boot held");
    drive(1, 20'h00000, 0, 0, 5'b11111, 0, "R7 none enabled again");

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule